// File: doc/BRIEF.md
# Memory region wait-state controller

This block sits between a processor bus master and external memory. It holds a table of programmable address regions. For every access it selects the first region that contains the address and checks that the region allows the access direction. It then stretches the transfer by a whole number of clock cycles, worked out from the region's access times in nanoseconds and a programmable clock period. Each region has its own pair of read times and its own pair of write times. The first time of each pair applies to a nonsequential access and the second to a sequential one.

A region whose data bus is narrower than the access splits the access into several memory beats, and every beat after the first uses sequential timing. A region on a 32-bit bus can be marked to keep the upper halfword of a fetch in a latch. A following sequential halfword read of that upper half is then answered at once, without a memory strobe.

Software writes one whole region entry, or the clock period, through the configuration port. Every such write restarts a serial conversion of all stored times into cycle counts, by repeated subtraction, and accesses stall until the conversion completes.

Top module: `mem_wait_ctrl`

## Requirements
- R1: After reset, `ready_o`, `err_o` and `mem_stb_o` are low while no request is pending, every region is disabled, and the clock period register holds `PERIOD_RST` ns.
- R2: A stored time `t` ns becomes ceil(t / period) cycles. A time of 0 becomes 1 cycle.
- R3: A sequential time field of 0 means the sequential time equals the nonsequential time of the same direction.
- R4: A region matches when it is enabled and `base <= addr < base + size`. When several regions match, the lowest index wins, even if that region refuses the access.
- R5: Permission code `cfg_perm_i`: bit 0 allows reads and bit 1 allows writes (00 none, 01 read-only, 10 write-only, 11 read-write). A refused access completes in one cycle with `ready_o` and `err_o` high and no `mem_stb_o`.
- R6: An access that matches no region completes in one cycle with `err_o` high and no `mem_stb_o`.
- R7: Access size `size_i` is 0 for a byte, 1 for a halfword and 2 for a word. Bus width code `cfg_bus_w_i` is 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. An access wider than the bus takes (access bytes / bus bytes) beats. The beats go to consecutive bus-width addresses from the size-aligned address, shown on `mem_addr_o`.
- R8: Each beat of `c` cycles holds `mem_stb_o` low for `c-1` cycles and high for one. `ready_o` rises with the last beat's strobe, so the total latency is the sum over the beats.
- R9: The first beat uses the access's own timing, selected by `we_i` and `seq_i`. Every later beat uses the sequential time of the same direction.
- R10: In a region marked with the latch flag on a 32-bit bus, a halfword or word read at a word address with `addr_i[1]`=0 loads the latch. A later sequential halfword read of the upper half of that word then completes in one cycle without `mem_stb_o`.
- R11: The latch is cleared by any nonsequential access or any write to its region.
- R12: Any region or period write restarts the cycle-count conversion. No access receives `ready_o` or `mem_stb_o` until the conversion ends, and a new period rescales every region's cycle counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_rgn_we_i | input | 1 | Write one region entry |
| cfg_idx_i | input | 3 | Region index to write |
| cfg_base_i | input | 32 | Region start address |
| cfg_size_i | input | 33 | Region size in bytes (up to the full space) |
| cfg_bus_w_i | input | 2 | Bus width code |
| cfg_perm_i | input | 2 | Permission code |
| cfg_hlatch_i | input | 1 | Upper-halfword latch flag |
| cfg_en_i | input | 1 | Region enable |
| cfg_rd_n_i | input | 10 | Nonsequential read time, ns |
| cfg_rd_s_i | input | 10 | Sequential read time, ns (0: same as N) |
| cfg_wr_n_i | input | 10 | Nonsequential write time, ns |
| cfg_wr_s_i | input | 10 | Sequential write time, ns (0: same as N) |
| cfg_period_we_i | input | 1 | Write clock period register |
| cfg_period_i | input | 10 | Clock period, ns (0 taken as 1) |
| req_i | input | 1 | Access request, held until ready |
| addr_i | input | 32 | Access address |
| we_i | input | 1 | Write access |
| seq_i | input | 1 | Sequential access |
| size_i | input | 2 | Access size code |
| ready_o | output | 1 | Access complete |
| err_o | output | 1 | Access refused or unmapped |
| mem_stb_o | output | 1 | Memory beat strobe |
| mem_we_o | output | 1 | Beat direction |
| mem_addr_o | output | 32 | Beat address |

## Verification
A wrong cycle count in the converted table shows up on the first access to that region as a latency that is off by whole cycles. The bench measures latency exactly from the first request cycle to `ready_o`. A wrong priority or match decision, or a bad permission bit, shows within one cycle as a wrong `err_o` or a missing strobe. A stale or missing latch entry shows on the next sequential halfword read, which then either takes memory timing or skips the strobe. A beat sequencing error shows as a wrong strobe count or a wrong last beat address.

// File: rtl/mwc_pkg.sv
package mwc_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_ACT = 1'b1} mwc_state_e;

  // timing kind index = {write, sequential}
  localparam logic [1:0] KIND_RD_N = 2'd0;
  localparam logic [1:0] KIND_RD_S = 2'd1;
  localparam logic [1:0] KIND_WR_N = 2'd2;
  localparam logic [1:0] KIND_WR_S = 2'd3;

  // log2 of bytes for size / bus width codes; code 3 acts as 32-bit
  function automatic logic [1:0] log_code(input logic [1:0] c);
    return (c == 2'd3) ? 2'd2 : c;
  endfunction
endpackage

// File: rtl/mwc_region_table.sv
module mwc_region_table import mwc_pkg::*; #(
  parameter int unsigned NUM_RGN = 8,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned TIME_W  = 10,
  localparam int unsigned IDX_W  = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1,
  localparam int unsigned SIZE_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_base_i,
  input  logic [SIZE_W-1:0] wr_size_i,
  input  logic [1:0]        wr_bw_i,
  input  logic [1:0]        wr_perm_i,
  input  logic              wr_hl_i,
  input  logic              wr_en_i,
  input  logic [TIME_W-1:0] wr_rd_n_i,
  input  logic [TIME_W-1:0] wr_rd_s_i,
  input  logic [TIME_W-1:0] wr_wr_n_i,
  input  logic [TIME_W-1:0] wr_wr_s_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [1:0]        hit_bw_o,
  output logic [1:0]        hit_perm_o,
  output logic              hit_hl_o,
  input  logic [IDX_W-1:0]  t_rgn_i,
  input  logic [1:0]        t_kind_i,
  output logic [TIME_W-1:0] t_o
);
  logic [ADDR_W-1:0] base_q [NUM_RGN];
  logic [SIZE_W-1:0] size_q [NUM_RGN];
  logic [1:0]        bw_q   [NUM_RGN];
  logic [1:0]        perm_q [NUM_RGN];
  logic              hl_q   [NUM_RGN];
  logic              en_q   [NUM_RGN];
  logic [TIME_W-1:0] rdn_q  [NUM_RGN];
  logic [TIME_W-1:0] rds_q  [NUM_RGN];
  logic [TIME_W-1:0] wrn_q  [NUM_RGN];
  logic [TIME_W-1:0] wrs_q  [NUM_RGN];
  logic [NUM_RGN-1:0] match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_RGN; i++) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
        bw_q[i]   <= '0;
        perm_q[i] <= '0;
        hl_q[i]   <= 1'b0;
        en_q[i]   <= 1'b0;
        rdn_q[i]  <= '0;
        rds_q[i]  <= '0;
        wrn_q[i]  <= '0;
        wrs_q[i]  <= '0;
      end
    end else if (wr_i) begin
      base_q[wr_idx_i] <= wr_base_i;
      size_q[wr_idx_i] <= wr_size_i;
      bw_q[wr_idx_i]   <= wr_bw_i;
      perm_q[wr_idx_i] <= wr_perm_i;
      hl_q[wr_idx_i]   <= wr_hl_i;
      en_q[wr_idx_i]   <= wr_en_i;
      rdn_q[wr_idx_i]  <= wr_rd_n_i;
      rds_q[wr_idx_i]  <= wr_rd_s_i;
      wrn_q[wr_idx_i]  <= wr_wr_n_i;
      wrs_q[wr_idx_i]  <= wr_wr_s_i;
    end
  end

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_match
    logic [SIZE_W-1:0] off;
    assign off      = {1'b0, addr_i} - {1'b0, base_q[g]};
    assign match[g] = en_q[g] && (addr_i >= base_q[g]) && (off < size_q[g]);
  end

  // lowest index wins
  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int i = NUM_RGN - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(i);
      end
    end
  end

  assign hit_bw_o   = bw_q[hit_idx_o];
  assign hit_perm_o = perm_q[hit_idx_o];
  assign hit_hl_o   = hl_q[hit_idx_o];

  always_comb begin
    unique case (t_kind_i)
      KIND_RD_N: t_o = rdn_q[t_rgn_i];
      KIND_RD_S: t_o = (rds_q[t_rgn_i] != '0) ? rds_q[t_rgn_i] : rdn_q[t_rgn_i];
      KIND_WR_N: t_o = wrn_q[t_rgn_i];
      default:   t_o = (wrs_q[t_rgn_i] != '0) ? wrs_q[t_rgn_i] : wrn_q[t_rgn_i];
    endcase
  end
endmodule

// File: rtl/mwc_cycle_calc.sv
module mwc_cycle_calc #(
  parameter int unsigned NUM_RGN = 8,
  parameter int unsigned TIME_W  = 10,
  parameter int unsigned CYC_W   = 8,
  localparam int unsigned IDX_W  = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1,
  localparam int unsigned ENT_W  = IDX_W + 2,
  localparam int unsigned NENT   = NUM_RGN * 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TIME_W-1:0] period_i,
  output logic [IDX_W-1:0]  sel_rgn_o,
  output logic [1:0]        sel_kind_o,
  input  logic [TIME_W-1:0] time_i,
  output logic              busy_o,
  input  logic [IDX_W-1:0]  lk_rgn_i,
  input  logic [1:0]        lk_kind_a_i,
  input  logic [1:0]        lk_kind_b_i,
  output logic [CYC_W-1:0]  cyc_a_o,
  output logic [CYC_W-1:0]  cyc_b_o
);
  logic [CYC_W-1:0]  cyc_q [NENT];
  logic [ENT_W-1:0]  ent_q;
  logic [TIME_W-1:0] rem_q;
  logic [CYC_W-1:0]  cnt_q;
  logic              busy_q, ld_q;

  assign sel_rgn_o  = ent_q[ENT_W-1:2];
  assign sel_kind_o = ent_q[1:0];
  assign busy_o     = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NENT; i++) cyc_q[i] <= CYC_W'(1);
      ent_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      ld_q   <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      ent_q  <= '0;
      ld_q   <= 1'b0;
    end else if (busy_q) begin
      if (!ld_q) begin
        rem_q <= time_i;
        cnt_q <= '0;
        ld_q  <= 1'b1;
      end else if (rem_q != '0) begin
        rem_q <= (rem_q > period_i) ? rem_q - period_i : '0;
        if (cnt_q != {CYC_W{1'b1}}) cnt_q <= cnt_q + CYC_W'(1);
      end else begin
        cyc_q[ent_q] <= (cnt_q == '0) ? CYC_W'(1) : cnt_q;
        ld_q         <= 1'b0;
        if (ent_q == ENT_W'(NENT - 1)) busy_q <= 1'b0;
        else                           ent_q  <= ent_q + ENT_W'(1);
      end
    end
  end

  assign cyc_a_o = cyc_q[{lk_rgn_i, lk_kind_a_i}];
  assign cyc_b_o = cyc_q[{lk_rgn_i, lk_kind_b_i}];
endmodule

// File: rtl/mem_wait_ctrl.sv
module mem_wait_ctrl import mwc_pkg::*; #(
  parameter int unsigned NUM_RGN    = 8,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned TIME_W     = 10,
  parameter int unsigned CYC_W      = 8,
  parameter int unsigned PERIOD_RST = 4,
  localparam int unsigned IDX_W     = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1,
  localparam int unsigned SIZE_W    = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_rgn_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [SIZE_W-1:0] cfg_size_i,
  input  logic [1:0]        cfg_bus_w_i,
  input  logic [1:0]        cfg_perm_i,
  input  logic              cfg_hlatch_i,
  input  logic              cfg_en_i,
  input  logic [TIME_W-1:0] cfg_rd_n_i,
  input  logic [TIME_W-1:0] cfg_rd_s_i,
  input  logic [TIME_W-1:0] cfg_wr_n_i,
  input  logic [TIME_W-1:0] cfg_wr_s_i,
  input  logic              cfg_period_we_i,
  input  logic [TIME_W-1:0] cfg_period_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              seq_i,
  input  logic [1:0]        size_i,
  output logic              ready_o,
  output logic              err_o,
  output logic              mem_stb_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  logic [TIME_W-1:0] period_q;
  logic              calc_start, calc_busy;
  logic              hit, hit_hl;
  logic [IDX_W-1:0]  hit_idx, t_rgn;
  logic [1:0]        hit_bw, hit_perm, t_kind;
  logic [TIME_W-1:0] t_val;
  logic [CYC_W-1:0]  cyc_a, cyc_b;

  mwc_state_e        st_q;
  logic [1:0]        beat_q, last_q, wlog_q;
  logic [CYC_W-1:0]  left_q, scyc_q;
  logic [ADDR_W-1:0] base_q;
  logic              we_q;

  logic                lat_vld_q;
  logic [IDX_W-1:0]    lat_rgn_q;
  logic [ADDR_W-3:0]   lat_word_q;

  logic              idle, take, perm_ok, bad, lat_hit, go, stb, done, lat_load, lat_clr;
  logic [1:0]        wlog_in, slog_in, blog_in, last_in, cur_beat, cur_last, cur_wlog;
  logic [CYC_W-1:0]  cur_left, cur_scyc;
  logic [ADDR_W-1:0] base_in, cur_base;

  assign calc_start = cfg_rgn_we_i | cfg_period_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              period_q <= TIME_W'(PERIOD_RST);
    else if (cfg_period_we_i) period_q <= (cfg_period_i == '0) ? TIME_W'(1) : cfg_period_i;
  end

  mwc_region_table #(
    .NUM_RGN(NUM_RGN), .ADDR_W(ADDR_W), .TIME_W(TIME_W)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cfg_rgn_we_i),
    .wr_idx_i   (cfg_idx_i),
    .wr_base_i  (cfg_base_i),
    .wr_size_i  (cfg_size_i),
    .wr_bw_i    (cfg_bus_w_i),
    .wr_perm_i  (cfg_perm_i),
    .wr_hl_i    (cfg_hlatch_i),
    .wr_en_i    (cfg_en_i),
    .wr_rd_n_i  (cfg_rd_n_i),
    .wr_rd_s_i  (cfg_rd_s_i),
    .wr_wr_n_i  (cfg_wr_n_i),
    .wr_wr_s_i  (cfg_wr_s_i),
    .addr_i     (addr_i),
    .hit_o      (hit),
    .hit_idx_o  (hit_idx),
    .hit_bw_o   (hit_bw),
    .hit_perm_o (hit_perm),
    .hit_hl_o   (hit_hl),
    .t_rgn_i    (t_rgn),
    .t_kind_i   (t_kind),
    .t_o        (t_val)
  );

  mwc_cycle_calc #(
    .NUM_RGN(NUM_RGN), .TIME_W(TIME_W), .CYC_W(CYC_W)
  ) u_calc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (calc_start),
    .period_i    (period_q),
    .sel_rgn_o   (t_rgn),
    .sel_kind_o  (t_kind),
    .time_i      (t_val),
    .busy_o      (calc_busy),
    .lk_rgn_i    (hit_idx),
    .lk_kind_a_i ({we_i, seq_i}),
    .lk_kind_b_i ({we_i, 1'b1}),
    .cyc_a_o     (cyc_a),
    .cyc_b_o     (cyc_b)
  );

  always_comb begin
    idle    = (st_q == ST_IDLE);
    take    = idle && req_i && !calc_busy && !calc_start;
    perm_ok = we_i ? hit_perm[1] : hit_perm[0];
    bad     = !hit || !perm_ok;
    wlog_in = log_code(hit_bw);
    slog_in = log_code(size_i);
    blog_in = (slog_in > wlog_in) ? slog_in - wlog_in : 2'd0;
    unique case (blog_in)
      2'd0:    last_in = 2'd0;
      2'd1:    last_in = 2'd1;
      default: last_in = 2'd3;
    endcase
    base_in = (blog_in == 2'd0) ? addr_i
                                : addr_i & ~((ADDR_W'(1) << slog_in) - ADDR_W'(1));
    lat_hit = lat_vld_q && (lat_rgn_q == hit_idx) && (lat_word_q == addr_i[ADDR_W-1:2])
              && !we_i && seq_i && (slog_in == 2'd1) && addr_i[1];
    lat_load = hit_hl && (wlog_in == 2'd2) && !we_i && (slog_in != 2'd0) && !addr_i[1];
    lat_clr  = lat_vld_q && (hit_idx == lat_rgn_q) && (we_i || !seq_i);
    go       = take && !bad && !lat_hit;

    cur_left = idle ? cyc_a   : left_q;
    cur_scyc = idle ? cyc_b   : scyc_q;
    cur_beat = idle ? 2'd0    : beat_q;
    cur_last = idle ? last_in : last_q;
    cur_wlog = idle ? wlog_in : wlog_q;
    cur_base = idle ? base_in : base_q;

    stb  = (go || !idle) && (cur_left == CYC_W'(1));
    done = stb && (cur_beat == cur_last);
  end

  assign mem_stb_o  = stb;
  assign ready_o    = (take && (bad || lat_hit)) || done;
  assign err_o      = take && bad;
  assign mem_we_o   = idle ? we_i : we_q;
  assign mem_addr_o = cur_base + (ADDR_W'(cur_beat) << cur_wlog);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      last_q <= '0;
      wlog_q <= '0;
      left_q <= CYC_W'(1);
      scyc_q <= CYC_W'(1);
      base_q <= '0;
      we_q   <= 1'b0;
    end else begin
      if (go || !idle) begin
        if (done) begin
          st_q <= ST_IDLE;
        end else begin
          st_q <= ST_ACT;
          if (stb) begin
            beat_q <= cur_beat + 2'd1;
            left_q <= cur_scyc;
          end else begin
            beat_q <= cur_beat;
            left_q <= cur_left - CYC_W'(1);
          end
        end
      end
      if (go) begin
        last_q <= last_in;
        wlog_q <= wlog_in;
        scyc_q <= cyc_b;
        base_q <= base_in;
        we_q   <= we_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_vld_q  <= 1'b0;
      lat_rgn_q  <= '0;
      lat_word_q <= '0;
    end else if (cfg_rgn_we_i && (cfg_idx_i == lat_rgn_q)) begin
      lat_vld_q <= 1'b0;
    end else if (take && !bad && !lat_hit) begin
      if (lat_load) begin
        lat_vld_q  <= 1'b1;
        lat_rgn_q  <= hit_idx;
        lat_word_q <= addr_i[ADDR_W-1:2];
      end else if (lat_clr) begin
        lat_vld_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mem_wait_ctrl_chk.sv
module mem_wait_ctrl_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              seq_i,
  input logic [1:0]        size_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ready_o,
  input logic              err_o,
  input logic              mem_stb_o,
  input logic              calc_busy_i
);
  // refused or unmapped: single response cycle, no strobe
  p_err_no_stb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ready_o && !mem_stb_o));

  // strobe-less success only for a sequential upper-half halfword read
  p_latch_only_seq_half_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !err_o && !mem_stb_o) |-> (!we_i && seq_i && (size_i == 2'd1) && addr_i[1]));

  p_resp_needs_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o || mem_stb_o || err_o) |-> req_i);

  p_stall_recompute_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    calc_busy_i |-> (!ready_o && !mem_stb_o));

  p_err_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !$past(err_o) && $past(rst_ni)) |=> !err_o || $past(req_i));
endmodule

bind mem_wait_ctrl mem_wait_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .seq_i       (seq_i),
  .size_i      (size_i),
  .addr_i      (addr_i),
  .ready_o     (ready_o),
  .err_o       (err_o),
  .mem_stb_o   (mem_stb_o),
  .calc_busy_i (calc_busy)
);

// File: tb/mem_wait_ctrl_bench.sv
module mem_wait_ctrl_bench;
  localparam int AW = 32;
  localparam int TW = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          cfg_rgn_we, cfg_hl, cfg_en, cfg_period_we;
  logic [2:0]    cfg_idx;
  logic [AW-1:0] cfg_base;
  logic [AW:0]   cfg_size;
  logic [1:0]    cfg_bw, cfg_perm;
  logic [TW-1:0] cfg_rdn, cfg_rds, cfg_wrn, cfg_wrs, cfg_period;
  logic          req, we, seq;
  logic [AW-1:0] addr;
  logic [1:0]    size;
  logic          ready, err, stb, mwe;
  logic [AW-1:0] maddr;

  mem_wait_ctrl u_mem_wait_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_rgn_we_i(cfg_rgn_we), .cfg_idx_i(cfg_idx), .cfg_base_i(cfg_base),
    .cfg_size_i(cfg_size), .cfg_bus_w_i(cfg_bw), .cfg_perm_i(cfg_perm),
    .cfg_hlatch_i(cfg_hl), .cfg_en_i(cfg_en),
    .cfg_rd_n_i(cfg_rdn), .cfg_rd_s_i(cfg_rds), .cfg_wr_n_i(cfg_wrn), .cfg_wr_s_i(cfg_wrs),
    .cfg_period_we_i(cfg_period_we), .cfg_period_i(cfg_period),
    .req_i(req), .addr_i(addr), .we_i(we), .seq_i(seq), .size_i(size),
    .ready_o(ready), .err_o(err), .mem_stb_o(stb), .mem_we_o(mwe), .mem_addr_o(maddr)
  );

  typedef struct {
    int          lat;
    bit          err;
    int          stbs;
    logic [31:0] last;
    bit          min_only;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_err = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // monitor: measures each access and pops the expected item
  initial begin
    int m_lat = 0;
    int m_stbs = 0;
    logic [31:0] m_last = '0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && req) begin
        m_lat++;
        if (stb) begin
          m_stbs++;
          m_last = maddr;
          check(mwe == we, "R7", "beat direction", longint'(mwe), longint'(we));
        end
        if (ready) begin
          if (q.size() == 0) begin
            check(1'b0, "R8", "unexpected completion", 1, 0);
          end else begin
            e = q.pop_front();
            if (e.min_only)
              check(m_lat >= e.lat, e.tag, "stalled latency", m_lat, e.lat);
            else
              check(m_lat == e.lat, e.tag, "latency", m_lat, e.lat);
            check(err == e.err, e.tag, "error flag", longint'(err), longint'(e.err));
            check(m_stbs == e.stbs, e.tag, "strobe count", m_stbs, e.stbs);
            if (e.stbs > 0)
              check(m_last == e.last, e.tag, "last beat address", longint'(m_last), longint'(e.last));
          end
          m_lat = 0;
          m_stbs = 0;
        end
      end
    end
  end

  // driver: pushes the expectation, then runs the request until ready
  task automatic acc(input logic [31:0] a, input bit w, input bit s, input logic [1:0] sz,
                     input int lat, input bit e, input int nstb, input logic [31:0] last,
                     input bit min_only, input string tag);
    exp_t it;
    it.lat = lat; it.err = e; it.stbs = nstb; it.last = last;
    it.min_only = min_only; it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
    req = 1'b1; addr = a; we = w; seq = s; size = sz;
    do @(negedge clk); while (!ready);
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic cfg_rgn(input int idx, input logic [31:0] base, input logic [32:0] sz,
                         input logic [1:0] bw, input logic [1:0] perm, input bit hl, input bit en,
                         input int rdn, input int rds, input int wrn, input int wrs);
    @(posedge clk); #1;
    cfg_rgn_we = 1'b1; cfg_idx = 3'(idx); cfg_base = base; cfg_size = sz;
    cfg_bw = bw; cfg_perm = perm; cfg_hl = hl; cfg_en = en;
    cfg_rdn = TW'(rdn); cfg_rds = TW'(rds); cfg_wrn = TW'(wrn); cfg_wrs = TW'(wrs);
    @(posedge clk); #1;
    cfg_rgn_we = 1'b0;
  endtask

  task automatic set_period(input int p);
    @(posedge clk); #1;
    cfg_period_we = 1'b1; cfg_period = TW'(p);
    @(posedge clk); #1;
    cfg_period_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not end, actual 0 expected 1");
    summary();
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; seq = 1'b0; size = '0; addr = '0;
    cfg_rgn_we = 1'b0; cfg_period_we = 1'b0; cfg_idx = '0; cfg_base = '0; cfg_size = '0;
    cfg_bw = '0; cfg_perm = '0; cfg_hl = 1'b0; cfg_en = 1'b0;
    cfg_rdn = '0; cfg_rds = '0; cfg_wrn = '0; cfg_wrs = '0; cfg_period = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b0, "R1", "ready after reset", longint'(ready), 0);
    check(err == 1'b0, "R1", "err after reset", longint'(err), 0);
    check(stb == 1'b0, "R1", "strobe after reset", longint'(stb), 0);
    // all regions disabled after reset
    acc(32'h0, 1'b0, 1'b0, 2'd2, 1, 1'b1, 0, 0, 1'b0, "R1");

    set_period(50);
    cfg_rgn(0, 32'h0,     33'h8000, 2'd2, 2'b11, 1'b0, 1'b1, 1, 1, 1, 1);
    cfg_rgn(1, 32'h8000,  33'h8000, 2'd1, 2'b01, 1'b0, 1'b1, 100, 100, 100, 100);
    cfg_rgn(2, 32'h10000, 33'h8000, 2'd1, 2'b11, 1'b0, 1'b1, 150, 100, 150, 100);
    cfg_rgn(3, 32'h20000, 33'h1000, 2'd2, 2'b11, 1'b1, 1'b1, 135, 85, 135, 0);
    cfg_rgn(4, 32'h40000, 33'h100,  2'd0, 2'b10, 1'b0, 1'b1, 60, 40, 60, 40);
    cfg_rgn(5, 32'h40000, 33'h1000, 2'd2, 2'b11, 1'b0, 1'b1, 200, 200, 0, 0);
    cfg_rgn(6, 32'h90000, 33'h1000, 2'd2, 2'b11, 1'b0, 1'b0, 1, 1, 1, 1);
    repeat (800) @(posedge clk);

    // R6: unmapped, and a disabled region does not match (R4)
    acc(32'h90000, 1'b0, 1'b0, 2'd2, 1, 1'b1, 0, 0, 1'b0, "R6");
    // R2: 1 ns at 50 ns period is one cycle
    acc(32'h4, 1'b0, 1'b0, 2'd2, 1, 1'b0, 1, 32'h4, 1'b0, "R2");
    // R7 R9: word read on 16-bit read-only region, two beats of 2
    acc(32'h8004, 1'b0, 1'b0, 2'd2, 4, 1'b0, 2, 32'h8006, 1'b0, "R7");
    // R5: write to read-only
    acc(32'h8000, 1'b1, 1'b0, 2'd1, 1, 1'b1, 0, 0, 1'b0, "R5");
    // R9: N beat 3 then S beat 2; sequential word 2+2
    acc(32'h10000, 1'b0, 1'b0, 2'd2, 5, 1'b0, 2, 32'h10002, 1'b0, "R9");
    acc(32'h10004, 1'b0, 1'b1, 2'd2, 4, 1'b0, 2, 32'h10006, 1'b0, "R9");
    // R8: single-beat writes, N=3 and S=2
    acc(32'h10008, 1'b1, 1'b0, 2'd1, 3, 1'b0, 1, 32'h10008, 1'b0, "R8");
    acc(32'h1000A, 1'b1, 1'b1, 2'd1, 2, 1'b0, 1, 32'h1000A, 1'b0, "R8");
    // R2: 135 ns -> 3 cycles; loads latch (R10)
    acc(32'h20000, 1'b0, 1'b0, 2'd2, 3, 1'b0, 1, 32'h20000, 1'b0, "R2");
    acc(32'h20002, 1'b0, 1'b1, 2'd1, 1, 1'b0, 0, 0, 1'b0, "R10");
    // R3: write S field 0 -> N time 135 -> 3; write clears latch (R11)
    acc(32'h20010, 1'b1, 1'b1, 2'd1, 3, 1'b0, 1, 32'h20010, 1'b0, "R3");
    acc(32'h20002, 1'b0, 1'b1, 2'd1, 2, 1'b0, 1, 32'h20002, 1'b0, "R11");
    // R11: nonsequential access clears latch
    acc(32'h20000, 1'b0, 1'b0, 2'd2, 3, 1'b0, 1, 32'h20000, 1'b0, "R10");
    acc(32'h20002, 1'b0, 1'b0, 2'd1, 3, 1'b0, 1, 32'h20002, 1'b0, "R11");
    acc(32'h20002, 1'b0, 1'b1, 2'd1, 2, 1'b0, 1, 32'h20002, 1'b0, "R11");
    // R4: overlap, lower index wins (write-only 8-bit region 4)
    acc(32'h40010, 1'b1, 1'b0, 2'd0, 2, 1'b0, 1, 32'h40010, 1'b0, "R4");
    acc(32'h40021, 1'b1, 1'b0, 2'd2, 5, 1'b0, 4, 32'h40023, 1'b0, "R7");
    acc(32'h40010, 1'b0, 1'b0, 2'd0, 1, 1'b1, 0, 0, 1'b0, "R4");
    // region 5 outside region 4; time 0 -> one cycle (R2)
    acc(32'h40800, 1'b0, 1'b0, 2'd2, 4, 1'b0, 1, 32'h40800, 1'b0, "R4");
    acc(32'h40800, 1'b1, 1'b0, 2'd2, 1, 1'b0, 1, 32'h40800, 1'b0, "R2");

    // catch-all with no permission placed last
    cfg_rgn(7, 32'h0, 33'h1_0000_0000, 2'd2, 2'b00, 1'b0, 1'b1, 1, 1, 1, 1);
    repeat (800) @(posedge clk);
    acc(32'h90000, 1'b1, 1'b0, 2'd2, 1, 1'b1, 0, 0, 1'b0, "R5");
    acc(32'h4, 1'b0, 1'b1, 2'd2, 1, 1'b0, 1, 32'h4, 1'b0, "R4");

    // R12: period change stalls, then rescales
    set_period(25);
    acc(32'h0, 1'b0, 1'b0, 2'd2, 2, 1'b0, 1, 32'h0, 1'b1, "R12");
    repeat (800) @(posedge clk);
    acc(32'h10000, 1'b0, 1'b0, 2'd1, 6, 1'b0, 1, 32'h10000, 1'b0, "R12");
    acc(32'h10002, 1'b0, 1'b1, 2'd1, 4, 1'b0, 1, 32'h10002, 1'b0, "R12");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R8", "pending expectations", q.size(), 0);
    summary();
  end
endmodule